// File: doc/BRIEF.md
# Deep-Stop Wake I/O Retention Controller

This block sequences a deep stop state in which the core logic is powered down while the pads keep driving. A stop request in normal operation freezes every pad's output and direction value in a bank of retention registers and then holds the core in reset for the whole stop. An enabled wake event from the always-on timer ends the stop. The block then drives a core reset pulse of fixed length, equivalent to power-on, and raises a recovered-from-power-down flag that boot code reads to pick its recovery path.

The pads stay frozen through the wake reset and the recovery phase, whatever the core reset does to the port registers. They open only when software writes the acknowledge bit. From that cycle each pin follows its live source: the peripheral when the per-pin peripheral enable is high, otherwise the port registers. If software sets the reset-pin enable again before acknowledging, a second reset pulse follows and ends with the flag cleared and the latches open. A separate output tells the power domain whether the low-power low-range oscillator stays running during the stop.

All interfaces are plain control and status pins. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure. A register write is a single-cycle strobe that takes effect at the clock edge where `reg_we` is high.

Top module: `deepstop_retain`

## Requirements
- R1: After a true power-on reset (`por_n` low), `reg_rdata` reads 0, `core_rst_n` is 1 and every pad follows its live source.
- R2: `stop_req` is accepted only in normal operation. At the accepting edge the pad output and direction values are captured. For the one following cycle `core_rst_n` stays 1, and it is then 0 for the whole deep stop. A `stop_req` during recovery is ignored.
- R3: In deep stop, `rtc_wake` ends the stop only when `rtc_wake_en` is 1. Otherwise the block stays in deep stop with the core held in reset.
- R4: A wake drives `core_rst_n` low for exactly RST_CYCLES clock cycles, then releases it.
- R5: The wake sets the read-only flag at `reg_rdata` bit 0. The flag stays 1 until an acknowledge or the end of a second reset.
- R6: From capture until the latches open, `pad_out` and `pad_oe` keep the captured values whatever the live inputs do.
- R7: A write with bit 1 (acknowledge) set, made while the flag is 1 and no second reset is in progress, clears the flag and opens the latches at that edge. Bit 1 always reads 0, and a write with bit 1 clear leaves the flag and the latches unchanged.
- R8: An acknowledge written while the flag is 0 has no effect on the pads or on the flag.
- R9: Per pin, the live source is the peripheral value pair when `periph_en` is 1 for that pin, and the port value pair otherwise.
- R10: Bit 2 (reset-pin enable) is read/write, is cleared by the wake and by power-on reset, and keeps any value written in normal operation.
- R11: Writing bit 2 from 0 to 1 with bit 1 clear, while the flag is 1, starts a second reset: `core_rst_n` is low for RST_CYCLES cycles, then the flag is 0, the latches are open and bit 2 reads 1. A single write that sets both bits 1 and 2 acts as an acknowledge only, and no reset follows.
- R12: A power-on reset during recovery clears the flag and bit 2 and opens the latches.
- R13: `osc_keep_on` is 1 in deep stop when the low-power low-range oscillator was running and the clock module was not in internal-reference mode at the accepting edge, or when `osc_stop_en` is 1. It is 0 outside deep stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_n | input | 1 | True power-on reset, active low, asynchronous |
| stop_req | input | 1 | Request to enter deep stop |
| rtc_wake | input | 1 | Wake event from the always-on timer |
| rtc_wake_en | input | 1 | Timer wake enable |
| osc_lplr_on | input | 1 | Low-power low-range oscillator is running |
| clk_int_ref | input | 1 | Clock module runs from the internal reference |
| osc_stop_en | input | 1 | Oscillator stop-enable setting |
| osc_keep_on | output | 1 | Keep the oscillator powered during deep stop |
| core_rst_n | output | 1 | Core reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Write data: bit1 acknowledge, bit2 reset-pin enable |
| reg_rdata | output | REG_W | Read data: bit0 flag, bit1 always 0, bit2 reset-pin enable |
| port_out | input | NPINS | Port output values |
| port_oe | input | NPINS | Port direction values |
| periph_en | input | NPINS | Per-pin peripheral ownership |
| periph_out | input | NPINS | Peripheral output values |
| periph_oe | input | NPINS | Peripheral direction values |
| pad_out | output | NPINS | Pad output value |
| pad_oe | output | NPINS | Pad output enable |

## Verification
The bench changes the live port values at each stage of stop and recovery. A design that captured a cycle late, or released the latches on the core reset, would show the reset-time port values on the pads instead of the frozen pattern. It measures the length of both reset pulses to catch off-by-one counters. It checks that an acknowledge written as 0, an acknowledge with the flag clear, and a combined acknowledge with reset-pin enable do not start a spurious reset or clear the flag. It also checks that a disabled timer event cannot end the stop, and that the oscillator stays on unless the internal reference was chosen.

// File: rtl/deepstop_retain_pkg.sv
package deepstop_retain_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_ENTER = 3'd1,
    ST_DEEP  = 3'd2,
    ST_WRST  = 3'd3,
    ST_RECOV = 3'd4
  } ds_state_t;

  localparam int FLAG_BIT = 0;
  localparam int ACK_BIT  = 1;
  localparam int RPE_BIT  = 2;

endpackage

// File: rtl/dsr_fsm.sv
module dsr_fsm
  import deepstop_retain_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic      clk,
  input  logic      por_n,
  input  logic      stop_req,
  input  logic      wake,
  input  logic      ack_ok,
  input  logic      sr_start,
  output ds_state_t state,
  output logic      capture,
  output logic      wake_evt,
  output logic      sr_end,
  output logic      sr_active,
  output logic      core_rst_n
);

  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(RST_CYCLES - 1);

  ds_state_t     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          sr_q, sr_d;

  assign capture  = (state_q == ST_RUN) && stop_req;
  assign wake_evt = (state_q == ST_DEEP) && wake;
  assign sr_end   = (state_q == ST_RECOV) && sr_q && (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sr_d    = sr_q;
    unique case (state_q)
      ST_RUN:   if (stop_req) state_d = ST_ENTER;
      ST_ENTER: state_d = ST_DEEP;
      ST_DEEP: begin
        if (wake) begin
          state_d = ST_WRST;
          cnt_d   = '0;
        end
      end
      ST_WRST: begin
        if (cnt_q == CNT_LAST) begin
          state_d = ST_RECOV;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RECOV: begin
        if (sr_q) begin
          if (cnt_q == CNT_LAST) begin
            sr_d    = 1'b0;
            cnt_d   = '0;
            state_d = ST_RUN;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else if (ack_ok) begin
          state_d = ST_RUN;
        end else if (sr_start) begin
          sr_d  = 1'b1;
          cnt_d = '0;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      sr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sr_q    <= sr_d;
    end
  end

  assign state      = state_q;
  assign sr_active  = sr_q;
  assign core_rst_n = !((state_q == ST_DEEP) || (state_q == ST_WRST) || sr_q);

endmodule

// File: rtl/dsr_regs.sv
module dsr_regs
  import deepstop_retain_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             core_rst_n,
  input  ds_state_t        state,
  input  logic             sr_active,
  input  logic             wake_evt,
  input  logic             sr_end,
  output logic             ack_ok,
  output logic             sr_start,
  output logic             flag,
  output logic [REG_W-1:0] reg_rdata
);

  logic flag_q, rpe_q, we_ok, in_recov;

  assign we_ok    = reg_we && core_rst_n;
  assign in_recov = (state == ST_RECOV) && flag_q && !sr_active;
  assign ack_ok   = we_ok && reg_wdata[ACK_BIT] && in_recov;
  assign sr_start = we_ok && reg_wdata[RPE_BIT] && !reg_wdata[ACK_BIT]
                    && !rpe_q && in_recov;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flag_q <= 1'b0;
    end else if (wake_evt) begin
      flag_q <= 1'b1;
    end else if (ack_ok || sr_end) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rpe_q <= 1'b0;
    end else if (wake_evt) begin
      rpe_q <= 1'b0;
    end else if (we_ok) begin
      rpe_q <= reg_wdata[RPE_BIT];
    end
  end

  always_comb begin
    reg_rdata           = '0;
    reg_rdata[FLAG_BIT] = flag_q;
    reg_rdata[RPE_BIT]  = rpe_q;
  end

  assign flag = flag_q;

endmodule

// File: rtl/dsr_pad_hold.sv
module dsr_pad_hold #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             capture,
  input  logic             release_hold,
  input  logic [NPINS-1:0] port_out,
  input  logic [NPINS-1:0] port_oe,
  input  logic [NPINS-1:0] periph_en,
  input  logic [NPINS-1:0] periph_out,
  input  logic [NPINS-1:0] periph_oe,
  output logic             hold_active,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);

  logic hold_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            hold_q <= 1'b0;
    else if (capture)      hold_q <= 1'b1;
    else if (release_hold) hold_q <= 1'b0;
  end

  assign hold_active = hold_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic live_out, live_oe, kept_out, kept_oe;

    assign live_out = periph_en[i] ? periph_out[i] : port_out[i];
    assign live_oe  = periph_en[i] ? periph_oe[i]  : port_oe[i];

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        kept_out <= 1'b0;
        kept_oe  <= 1'b0;
      end else if (capture) begin
        kept_out <= live_out;
        kept_oe  <= live_oe;
      end
    end

    assign pad_out[i] = hold_q ? kept_out : live_out;
    assign pad_oe[i]  = hold_q ? kept_oe  : live_oe;
  end

endmodule

// File: rtl/deepstop_retain.sv
module deepstop_retain
  import deepstop_retain_pkg::*;
#(
  parameter int NPINS      = 8,
  parameter int REG_W      = 8,
  parameter int RST_CYCLES = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             stop_req,
  input  logic             rtc_wake,
  input  logic             rtc_wake_en,
  input  logic             osc_lplr_on,
  input  logic             clk_int_ref,
  input  logic             osc_stop_en,
  output logic             osc_keep_on,
  output logic             core_rst_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [NPINS-1:0] port_out,
  input  logic [NPINS-1:0] port_oe,
  input  logic [NPINS-1:0] periph_en,
  input  logic [NPINS-1:0] periph_out,
  input  logic [NPINS-1:0] periph_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);

  ds_state_t state_q;
  logic capture, wake_evt, sr_end, sr_active, ack_ok, sr_start;
  logic flag, hold_active, osc_lock_q;

  dsr_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
    .clk        (clk),
    .por_n      (por_n),
    .stop_req   (stop_req),
    .wake       (rtc_wake && rtc_wake_en),
    .ack_ok     (ack_ok),
    .sr_start   (sr_start),
    .state      (state_q),
    .capture    (capture),
    .wake_evt   (wake_evt),
    .sr_end     (sr_end),
    .sr_active  (sr_active),
    .core_rst_n (core_rst_n)
  );

  dsr_regs #(.REG_W(REG_W)) u_regs (
    .clk        (clk),
    .por_n      (por_n),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .core_rst_n (core_rst_n),
    .state      (state_q),
    .sr_active  (sr_active),
    .wake_evt   (wake_evt),
    .sr_end     (sr_end),
    .ack_ok     (ack_ok),
    .sr_start   (sr_start),
    .flag       (flag),
    .reg_rdata  (reg_rdata)
  );

  dsr_pad_hold #(.NPINS(NPINS)) u_pads (
    .clk          (clk),
    .por_n        (por_n),
    .capture      (capture),
    .release_hold (ack_ok || sr_end),
    .port_out     (port_out),
    .port_oe      (port_oe),
    .periph_en    (periph_en),
    .periph_out   (periph_out),
    .periph_oe    (periph_oe),
    .hold_active  (hold_active),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       osc_lock_q <= 1'b0;
    else if (capture) osc_lock_q <= osc_lplr_on && !clk_int_ref;
  end

  assign osc_keep_on = (state_q == ST_DEEP) && (osc_lock_q || osc_stop_en);

endmodule

// File: rtl/deepstop_retain_chk.sv
module deepstop_retain_chk
  import deepstop_retain_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             por_n,
  input ds_state_t        state_q,
  input logic             flag,
  input logic             hold_active,
  input logic             core_rst_n,
  input logic             osc_keep_on,
  input logic [REG_W-1:0] reg_rdata,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe
);

  p_enter_to_deep_r2: assert property (@(posedge clk) disable iff (!por_n)
    state_q == ST_ENTER |=> state_q == ST_DEEP);

  p_core_held_deep_r2: assert property (@(posedge clk) disable iff (!por_n)
    state_q == ST_DEEP |-> !core_rst_n && hold_active);

  p_core_held_wake_r4: assert property (@(posedge clk) disable iff (!por_n)
    state_q == ST_WRST |-> !core_rst_n);

  p_flag_from_wake_r5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(flag) |-> $past(state_q) == ST_DEEP);

  p_pads_frozen_r6: assert property (@(posedge clk) disable iff (!por_n)
    hold_active && $past(hold_active) |-> $stable(pad_out) && $stable(pad_oe));

  p_ack_reads_zero_r7: assert property (@(posedge clk) disable iff (!por_n)
    reg_rdata[ACK_BIT] == 1'b0);

  p_exit_clears_r11: assert property (@(posedge clk) disable iff (!por_n)
    state_q == ST_RUN && $past(state_q) == ST_RECOV |-> !flag && !hold_active);

  p_osc_only_deep_r13: assert property (@(posedge clk) disable iff (!por_n)
    state_q != ST_DEEP |-> !osc_keep_on);

endmodule

bind deepstop_retain deepstop_retain_chk #(.NPINS(NPINS), .REG_W(REG_W)) u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .state_q     (state_q),
  .flag        (flag),
  .hold_active (hold_active),
  .core_rst_n  (core_rst_n),
  .osc_keep_on (osc_keep_on),
  .reg_rdata   (reg_rdata),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe)
);

// File: tb/sim_deepstop_retain.sv
module sim_deepstop_retain;
  localparam int N   = 8;
  localparam int W   = 8;
  localparam int RST = 4;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic stop_req = 0, rtc_wake = 0, rtc_wake_en = 0;
  logic osc_lplr_on = 0, clk_int_ref = 0, osc_stop_en = 0;
  logic osc_keep_on, core_rst_n, reg_we = 0;
  logic [W-1:0] reg_wdata = '0, reg_rdata;
  logic [N-1:0] port_out = '0, port_oe = '0, periph_en = '0;
  logic [N-1:0] periph_out = '0, periph_oe = '0, pad_out, pad_oe;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  deepstop_retain #(.NPINS(N), .REG_W(W), .RST_CYCLES(RST)) u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [W-1:0] d);
    @(negedge clk); reg_we = 1; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_wdata = '0;
  endtask

  task automatic do_por();
    @(negedge clk); por_n = 0;
    @(negedge clk); por_n = 1;
    tick();
  endtask

  task automatic enter_stop();
    @(negedge clk); stop_req = 1;
    @(negedge clk); stop_req = 0;
    check("R2 capture cycle keeps core out of reset", core_rst_n, 1);
    tick();
    check("R2 core held in deep stop", core_rst_n, 0);
  endtask

  task automatic count_low(string req, int exp);
    int n = 0;
    while (!core_rst_n && n < 100) begin n++; tick(); end
    check(req, n, exp);
  endtask

  task automatic wake_up();
    rtc_wake_en = 1;
    @(negedge clk); rtc_wake = 1;
    @(negedge clk); rtc_wake = 0;
    count_low("R4 wake reset length", RST);
  endtask

  task automatic t_reset();
    port_out = 8'h3C; port_oe = 8'hFF; tick();
    check("R1 rdata after POR", reg_rdata, 0);
    check("R1 core reset released", core_rst_n, 1);
    check("R1 pads live", {pad_out, pad_oe}, {8'h3C, 8'hFF});
  endtask

  task automatic t_stop_and_wake();
    port_out = 8'hA5; port_oe = 8'hF0;
    wr(8'h04);
    check("R10 rpe written in run", reg_rdata, 8'h04);
    enter_stop();
    port_out = 8'h00; port_oe = 8'h00; tick();
    check("R6 pads frozen in deep stop", {pad_out, pad_oe}, {8'hA5, 8'hF0});
    rtc_wake_en = 0;
    @(negedge clk); rtc_wake = 1; tick(3); rtc_wake = 0;
    check("R3 disabled wake ignored", core_rst_n, 0);
    wake_up();
    check("R5 flag set and R10 rpe cleared", reg_rdata, 8'h01);
    check("R6 pads frozen in recovery", {pad_out, pad_oe}, {8'hA5, 8'hF0});
  endtask

  task automatic t_ack_zero();
    wr(8'h00);
    check("R7 zero ack keeps flag", reg_rdata[0], 1);
    check("R7 zero ack keeps pads", pad_out, 8'hA5);
    @(negedge clk); stop_req = 1; tick(); stop_req = 0; tick();
    check("R2 stop ignored in recovery", core_rst_n, 1);
    check("R2 stop ignored, pads", pad_out, 8'hA5);
  endtask

  task automatic t_ack_open();
    port_out = 8'h5A; port_oe = 8'h0F; periph_en = 8'h81;
    periph_out = 8'h80; periph_oe = 8'h01;
    wr(8'h02);
    check("R7 ack clears flag, ack reads 0", reg_rdata, 8'h00);
    check("R9 pads live after ack", {pad_out, pad_oe}, {8'hDA, 8'h0F});
    periph_en = 8'h00; tick();
    check("R9 port source", pad_out, 8'h5A);
  endtask

  task automatic t_ack_idle();
    wr(8'h02);
    check("R8 ack with flag clear", reg_rdata, 8'h00);
    check("R8 pads still live", pad_out, 8'h5A);
    check("R8 no reset", core_rst_n, 1);
  endtask

  task automatic t_second_reset();
    port_out = 8'hC3; port_oe = 8'hAA;
    enter_stop();
    port_out = 8'h11; wake_up();
    @(negedge clk); reg_we = 1; reg_wdata = 8'h04;
    @(negedge clk); reg_we = 0; reg_wdata = '0;
    count_low("R11 second reset length", RST);
    check("R11 flag cleared, rpe kept", reg_rdata, 8'h04);
    check("R11 latches open", pad_out, 8'h11);
  endtask

  task automatic t_ack_with_rpe();
    wr(8'h00);
    port_out = 8'h77; enter_stop(); port_out = 8'h22; wake_up();
    wr(8'h06);
    check("R11 combined write no reset", core_rst_n, 1);
    check("R11 combined write acks", reg_rdata, 8'h04);
    check("R11 combined write opens", pad_out, 8'h22);
  endtask

  task automatic t_por_recovery();
    port_out = 8'h99; enter_stop(); port_out = 8'h44; wake_up();
    check("R12 pre: held", pad_out, 8'h99);
    do_por();
    check("R12 POR clears regs", reg_rdata, 8'h00);
    check("R12 POR opens latches", pad_out, 8'h44);
  endtask

  task automatic t_osc();
    osc_lplr_on = 1; clk_int_ref = 0; osc_stop_en = 0; tick();
    check("R13 off in run", osc_keep_on, 0);
    enter_stop();
    check("R13 lp osc kept on", osc_keep_on, 1);
    wake_up(); wr(8'h02);
    clk_int_ref = 1; enter_stop();
    check("R13 internal ref stops osc", osc_keep_on, 0);
    osc_stop_en = 1; tick();
    check("R13 stop enable keeps osc", osc_keep_on, 1);
    osc_stop_en = 0;
    wake_up(); wr(8'h02);
  endtask

  initial begin
    tick(2); por_n = 1; tick();
    t_reset();
    t_stop_and_wake();
    t_ack_zero();
    t_ack_open();
    t_ack_idle();
    t_second_reset();
    t_ack_with_rpe();
    t_por_recovery();
    t_osc();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule